// File: doc/BRIEF.md
# Codec Status-Slot Request Generator

This block sits on the codec side of a frame-based serial audio link. Once per frame it builds the 20-bit status word for input Slot 1 and the tag bits for Slots 1 and 2. A serializer elsewhere sends these values. The word has two parts. The first is the index of a control register whose read is being answered in this frame. The second is ten active-low request flags, one for each output slot from 3 to 12. Each flag tells the controller whether to send a sample for that slot in the next frame.

Every channel behaves in one of three ways. A channel that is unsupported, built without variable-rate capability, or powered down always asks for data by showing a flag of 0. A channel that has just left power-down shows a flag of 1 for a programmable number of frames while it warms up. After that, a channel in variable-rate mode running below the base rate uses a phase accumulator to decide, frame by frame, whether it needs a sample.

All outputs are registered. They change only on the clock after the frame-sync pulse and hold their values for the rest of the frame.

Top module: `s1_status_gen`

## Requirements
- R1: Word bit 19 and bits 1..0 are 0 in every cycle.
- R2: A read request with a 7-bit index, taken in the frame sync cycle or any cycle of frame N, places that index in bits 18..12 for frame N+1. If several requests arrive in one frame, the last one wins. In a frame with no returned read, bits 18..12 are 0.
- R3: Both tag outputs are 1 exactly in frames that return a read, including a read of index 0. Otherwise they are 0. The tags never depend on the request flags.
- R4: A channel whose power-down input is 1 at a frame boundary shows flag 0 for that frame, and its warm-up is restarted.
- R5: The flag of an unsupported slot (parameter mask bit i for slot i+3 is clear) is always 0. When the block is built without variable-rate capability, every flag is always 0.
- R6: After a channel's power-down input clears, its flag is 1 for exactly `warm_frames` frames. Normal behaviour starts in the next frame. With `warm_frames` at 0, normal behaviour starts at once.
- R7: A ready channel with variable-rate mode disabled shows flag 0.
- R8: A ready channel whose rate is 48000 Hz or higher shows flag 0.
- R9: A ready variable-rate channel below 48000 Hz adds its rate to an accumulator that starts at 0. If the sum is 48000 or more, the accumulator keeps the sum minus 48000 and the flag is 0. Otherwise the accumulator keeps the sum and the flag is 1. The accumulator returns to 0 whenever the channel is not in this state.
- R10: Word and tags change only on the clock edge that follows a cycle with frame_sync high.
- R11: The flag for output slot s (3..12) sits at word bit 14-s, so slot 3 is bit 11 and slot 12 is bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-clock-derived system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse at each frame boundary |
| vra_en | input | 10 | Per-channel variable-rate enable, bit i = slot i+3 |
| pwr_down | input | 10 | Per-channel power-down control, bit i = slot i+3 |
| rate_flat | input | 160 | Per-channel sample rate in Hz, channel i at bits 16i+15..16i |
| warm_frames | input | 8 | Frames of forced flag 1 after power-up |
| rd_req | input | 1 | Register read request strobe |
| rd_idx | input | 7 | Register index of the read request |
| slot1_word | output | 20 | Slot 1 status word |
| tag_slot1 | output | 1 | Slot 1 valid tag |
| tag_slot2 | output | 1 | Slot 2 valid tag |

## Verification
The bench targets several corner cases, and each one exposes a specific class of bug:
- A rate of exactly 48000 Hz and a rate of 47999 Hz. A design that used the wrong comparison would ask for the wrong frames.
- A read of index 0. If tags were derived from a nonzero index, this read would be lost.
- Two reads in one frame, and a read in the sync cycle itself. A design with an off-by-one on the frame would return the wrong index.
- A channel powered down again in the middle of warm-up, and a warm-up length of zero. A design that failed to restart or skip the warm-up would show the wrong number of 1 flags.

// File: rtl/s1st_pkg.sv
// Shared types for the status-slot generator.
// Assumes: nothing beyond IEEE 1800-2017.
package s1st_pkg;

    // Per-channel lifecycle: powered down, warming up, running.
    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WARM = 2'd1,
        CH_RUN  = 2'd2
    } chan_st_e;

endpackage

// File: rtl/s1st_chan.sv
// One output channel's request flag (active low: 0 = send a sample).
// Updates only when frame_sync is high. While powered, it counts
// warm_frames boundaries before reaching CH_RUN. In CH_RUN a phase
// accumulator decides whether a sample is needed.
// Assumes: rate < 2**RATE_W and BASE_HZ < 2**RATE_W.
module s1st_chan
    import s1st_pkg::*;
#(
    parameter int       RATE_W  = 16,
    parameter int       CNT_W   = 8,
    parameter int       BASE_HZ = 48000,
    parameter bit       ENABLED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              pwr_down,
    input  logic              vra_en,
    input  logic [RATE_W-1:0] rate,
    input  logic [CNT_W-1:0]  warm_frames,
    output logic              req_n
);
    localparam int ACC_W = RATE_W + 1;
    localparam logic [ACC_W-1:0] BASE = ACC_W'(BASE_HZ);

    chan_st_e         st_q,  st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ACC_W-1:0] acc_q, acc_d;
    logic             flag_q, flag_d;
    logic             eval;
    logic [ACC_W-1:0] sum;

    // Next-state logic for the boundary update.
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        acc_d  = acc_q;
        flag_d = flag_q;
        eval   = 1'b0;
        sum    = acc_q + {1'b0, rate};
        if (frame_sync) begin
            if (pwr_down) begin
                st_d   = CH_OFF;
                cnt_d  = '0;
                acc_d  = '0;
                flag_d = 1'b0;
            end else if (st_q != CH_RUN) begin
                if (cnt_q == warm_frames) begin
                    st_d = CH_RUN;
                    eval = 1'b1;
                end else begin
                    st_d   = CH_WARM;
                    cnt_d  = cnt_q + 1'b1;
                    acc_d  = '0;
                    flag_d = 1'b1;
                end
            end else begin
                eval = 1'b1;
            end
            if (eval) begin
                if (!vra_en || ({1'b0, rate} >= BASE)) begin
                    acc_d  = '0;
                    flag_d = 1'b0;
                end else if (sum >= BASE) begin
                    acc_d  = sum - BASE;
                    flag_d = 1'b0;
                end else begin
                    acc_d  = sum;
                    flag_d = 1'b1;
                end
            end
            if (!ENABLED) flag_d = 1'b0;
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CH_OFF;
            cnt_q  <= '0;
            acc_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            acc_q  <= acc_d;
            flag_q <= flag_d;
        end
    end

    assign req_n = flag_q;
endmodule

// File: rtl/s1st_rdret.sv
// Read-return tracker. Remembers the last read index requested
// during the current frame and presents it, with valid tags, for the
// following frame. A request in the sync cycle belongs to the new frame.
// Assumes: frame_sync is a one-cycle pulse.
module s1st_rdret #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             rd_req,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] ret_idx,
    output logic             ret_tag
);
    logic             pend_q;
    logic [IDX_W-1:0] pidx_q;

    // Capture requests and hand them out at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            pidx_q  <= '0;
            ret_idx <= '0;
            ret_tag <= 1'b0;
        end else if (frame_sync) begin
            ret_tag <= pend_q;
            ret_idx <= pend_q ? pidx_q : '0;
            pend_q  <= rd_req;
            pidx_q  <= rd_req ? rd_idx : '0;
        end else if (rd_req) begin
            pend_q <= 1'b1;
            pidx_q <= rd_idx;
        end
    end
endmodule

// File: rtl/s1_status_gen.sv
// Slot 1 status word and Slot 1/2 tag generator.
// Word layout: [top]=0, index, flags (slot 3 highest), two zero bits.
// Assumes: frame_sync is a one-cycle pulse once per frame; the
// serializer samples outputs during the frame that follows the pulse.
module s1_status_gen #(
    parameter int          NCH       = 10,
    parameter int          RATE_W    = 16,
    parameter int          IDX_W     = 7,
    parameter int          CNT_W     = 8,
    parameter int          BASE_HZ   = 48000,
    parameter bit          VAR_RATE  = 1'b1,
    parameter logic [9:0]  SUPPORTED = 10'b11_1111_1011
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_sync,
    input  logic [NCH-1:0]          vra_en,
    input  logic [NCH-1:0]          pwr_down,
    input  logic [NCH*RATE_W-1:0]   rate_flat,
    input  logic [CNT_W-1:0]        warm_frames,
    input  logic                    rd_req,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [IDX_W+NCH+2:0]    slot1_word,
    output logic                    tag_slot1,
    output logic                    tag_slot2
);
    localparam int WORD_W = IDX_W + NCH + 3;

    logic [NCH-1:0]   req_n;
    logic [NCH-1:0]   flags;
    logic [IDX_W-1:0] ret_idx;
    logic             ret_tag;

    // One request-flag engine per output slot.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        s1st_chan #(
            .RATE_W  (RATE_W),
            .CNT_W   (CNT_W),
            .BASE_HZ (BASE_HZ),
            .ENABLED (VAR_RATE && SUPPORTED[i])
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_sync  (frame_sync),
            .pwr_down    (pwr_down[i]),
            .vra_en      (vra_en[i]),
            .rate        (rate_flat[i*RATE_W +: RATE_W]),
            .warm_frames (warm_frames),
            .req_n       (req_n[i])
        );
        // Lowest slot lands in the highest flag bit.
        assign flags[NCH-1-i] = req_n[i];
    end

    s1st_rdret #(.IDX_W(IDX_W)) u_rdret (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .rd_req     (rd_req),
        .rd_idx     (rd_idx),
        .ret_idx    (ret_idx),
        .ret_tag    (ret_tag)
    );

    // Pack the word; reserved bits are tied low.
    assign slot1_word = WORD_W'({1'b0, ret_idx, flags, 2'b00});
    assign tag_slot1  = ret_tag;
    assign tag_slot2  = ret_tag;
endmodule

// File: rtl/s1_status_chk.sv
// Property checker for s1_status_gen, attached by bind below.
// Assumes: the same parameter values as the bound instance.
module s1_status_chk #(
    parameter int         NCH       = 10,
    parameter int         IDX_W     = 7,
    parameter bit         VAR_RATE  = 1'b1,
    parameter logic [9:0] SUPPORTED = 10'b11_1111_1011
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_sync,
    input logic [NCH-1:0]       pwr_down,
    input logic [IDX_W+NCH+2:0] word,
    input logic                 tag1,
    input logic                 tag2
);
    localparam int TOP = IDX_W + NCH + 2;

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (word[TOP] == 1'b0) && (word[1:0] == 2'b00));

    // R2
    idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (tag1 || (word[TOP-1 -: IDX_W] == '0)) && (tag1 == tag2));

    // R10
    hold_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(word) && $stable(tag1) && $stable(tag2));

    for (genvar i = 0; i < NCH; i++) begin : g_c
        // R4
        pdown_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_sync && pwr_down[i]) |=> (word[2+NCH-1-i] == 1'b0));
        if (!(VAR_RATE && SUPPORTED[i])) begin : g_uns
            // R5
            unsup_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                frame_sync |=> (word[2+NCH-1-i] == 1'b0));
        end
    end
endmodule

bind s1_status_gen s1_status_chk #(
    .NCH       (NCH),
    .IDX_W     (IDX_W),
    .VAR_RATE  (VAR_RATE),
    .SUPPORTED (SUPPORTED)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .pwr_down   (pwr_down),
    .word       (slot1_word),
    .tag1       (tag_slot1),
    .tag2       (tag_slot2)
);

// File: tb/s1_status_gen_test.sv
module s1_status_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 10;
    localparam logic [9:0] SUP = 10'b11_1111_1011;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_sync = 1'b0;
    logic [9:0]   vra_en = '0;
    logic [9:0]   pwr_down = '1;
    logic [159:0] rate_flat = '0;
    logic [7:0]   warm_frames = 8'd3;
    logic         rd_req = 1'b0;
    logic [6:0]   rd_idx = '0;
    logic [19:0]  slot1_word;
    logic         tag_slot1, tag_slot2;

    s1_status_gen uut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .vra_en(vra_en), .pwr_down(pwr_down), .rate_flat(rate_flat),
        .warm_frames(warm_frames), .rd_req(rd_req), .rd_idx(rd_idx),
        .slot1_word(slot1_word), .tag_slot1(tag_slot1), .tag_slot2(tag_slot2)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit started = 0;

    // Behavioural reference state
    int    acc [NCH];
    int    cnt [NCH];
    bit    rdy [NCH];
    int    expf [NCH];
    string why [NCH];
    int    pend = 0, pidx = 0, exp_idx = 0, exp_tag = 0;

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, got, exp);
        end
    endtask

    // Reference model, updated on the same edge as the design.
    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                acc[i] = 0; cnt[i] = 0; rdy[i] = 0; expf[i] = 0; why[i] = "R4";
            end
            pend = 0; pidx = 0; exp_idx = 0; exp_tag = 0;
        end else if (frame_sync) begin
            exp_tag = pend;
            exp_idx = pend ? pidx : 0;
            pend = rd_req;
            pidx = rd_req ? int'(rd_idx) : 0;
            for (int i = 0; i < NCH; i++) begin
                int r;
                r = int'(rate_flat[i*16 +: 16]);
                if (pwr_down[i]) begin
                    rdy[i] = 0; cnt[i] = 0; acc[i] = 0; expf[i] = 0; why[i] = "R4";
                end else begin
                    if (!rdy[i]) begin
                        if (cnt[i] == int'(warm_frames)) rdy[i] = 1;
                        else begin
                            cnt[i]++; acc[i] = 0; expf[i] = 1; why[i] = "R6";
                        end
                    end
                    if (rdy[i]) begin
                        if (!vra_en[i]) begin
                            acc[i] = 0; expf[i] = 0; why[i] = "R7";
                        end else if (r >= 48000) begin
                            acc[i] = 0; expf[i] = 0; why[i] = "R8";
                        end else begin
                            acc[i] = acc[i] + r;
                            why[i] = "R9";
                            if (acc[i] >= 48000) begin
                                acc[i] = acc[i] - 48000; expf[i] = 0;
                            end else expf[i] = 1;
                        end
                    end
                end
                if (!SUP[i]) begin
                    expf[i] = 0; why[i] = "R5";
                end
            end
        end else if (rd_req) begin
            pend = 1; pidx = int'(rd_idx);
        end
        if (cyc > 20000) begin
            fails++;
            $display("FAIL R10 watchdog: got no end expected end of stimulus");
            report();
        end
    end

    // Compare on every clock, away from the active edge (R10 holds via per-cycle compare).
    always @(negedge clk) begin
        if (started) begin
            check("R1", int'({slot1_word[19], slot1_word[1:0]}), 0);
            check("R2", int'(slot1_word[18:12]), exp_idx);
            check("R3", int'(tag_slot1), exp_tag);
            check("R3", int'(tag_slot2), exp_tag);
            for (int i = 0; i < NCH; i++) begin
                // R11: slot i+3 at bit 11-i
                check({why[i], " R11"}, int'(slot1_word[11-i]), expf[i]);
            end
        end
    end

    task automatic frame(input int nreq, input int idx0, input bit req_at_sync);
        @(negedge clk);
        frame_sync = 1'b1;
        rd_req = req_at_sync;
        rd_idx = 7'(idx0 + 9);
        @(negedge clk);
        frame_sync = 1'b0;
        rd_req = 1'b0;
        for (int k = 0; k < nreq; k++) begin
            rd_req = 1'b1;
            rd_idx = 7'(idx0 + k);
            @(negedge clk);
            rd_req = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_rate(input int ch, input int hz);
        rate_flat[ch*16 +: 16] = 16'(hz);
    endtask

    initial begin
        set_rate(0, 44100); set_rate(1, 8000);  set_rate(2, 22050);
        set_rate(3, 48000); set_rate(4, 32000); set_rate(5, 11025);
        set_rate(6, 0);     set_rate(7, 16000); set_rate(8, 47999);
        set_rate(9, 60000);
        vra_en = 10'b11_0111_1111;
        frame(0, 0, 1'b1);                       // sync during reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        frame(0, 0, 1'b0);
        frame(1, 5, 1'b0);                       // R4: all powered down
        pwr_down = '0;
        frame(2, 7'h26, 1'b0);                   // R2 last wins, R6 warm-up
        frame(0, 0, 1'b1);                       // request in sync cycle
        frame(1, 0, 1'b0);                       // R3: index 0 still tagged
        for (int f = 0; f < 10; f++) frame(f % 2, 7'h2A + f, 1'b0);
        vra_en[7] = 1'b1;                        // R7 -> R9
        for (int f = 0; f < 8; f++) frame(0, 0, 1'b0);
        pwr_down[1] = 1'b1;
        frame(0, 0, 1'b0); frame(0, 0, 1'b0);
        warm_frames = 8'd0;                      // R6 zero-length warm-up
        pwr_down[1] = 1'b0;
        for (int f = 0; f < 3; f++) frame(1, 7'h3E, 1'b0);
        warm_frames = 8'd2;
        pwr_down[4] = 1'b1; frame(0, 0, 1'b0);
        pwr_down[4] = 1'b0; frame(0, 0, 1'b0);
        pwr_down[4] = 1'b1; frame(0, 0, 1'b0);   // restart mid warm-up
        pwr_down[4] = 1'b0;
        for (int f = 0; f < 5; f++) frame(0, 0, 1'b0);
        set_rate(0, 48000);                      // R8 exact base rate
        for (int f = 0; f < 3; f++) frame(0, 0, 1'b0);
        set_rate(0, 44100);
        for (int f = 0; f < 6; f++) frame(0, 0, 1'b0);
        report();
    end
endmodule